// File: doc/BRIEF.md
# Instruction Prefix Byte Decoder

This block sits at the front of an instruction decode path. It takes instruction bytes one per cycle over a valid/ready handshake. While the bytes are prefixes, it folds them into an accumulated prefix state. The prefixes it recognises are lock, the two repeat forms, segment overrides, operand-size, address-size and REX.

The first byte that is not a prefix ends the scan. On that byte the block registers one descriptor. The descriptor carries:
- the resolved prefix flags
- the REX bits
- a flag marking a VEX escape
- the number of prefix bytes seen
- an error flag
- the terminating byte itself, reported as the opcode

The descriptor stays on the outputs until downstream accepts it. While it waits, the input side is stalled. Once it is accepted, every piece of prefix state returns to zero, so the next instruction starts clean.

Rules that depend on byte order are settled inside the block. These are: which repeat prefix wins, when operand-size is dropped, where REX may sit, and which bytes may precede a VEX escape. A mandatory-prefix input, `sse_class`, is sampled together with the opcode byte. It tells the block whether F2/F3 act as part of the opcode or as plain repeat prefixes.

Top module: `prefix_scan`

## Requirements
- R1: Byte encodings are as follows.
  - Prefix bytes: F0 (lock), F2 (repne), F3 (rep), 2E/36/3E/26/64/65 (segment), 66 (operand size), 67 (address size) and 40..4F (REX). Each prefix is consumed without producing a descriptor.
  - Every other byte ends the scan and is reported on `d_opcode`.
- R2: `d_seg` encodes the segment override as 0=none, 1=26, 2=2E, 3=36, 4=3E, 5=64, 6=65. When two overrides appear, the later one is reported. Lock (`d_lock`) and address size (`d_addr32`) are reported whatever their position among the other legacy prefixes.
- R3: F2 and F3 cancel each other, and only the later of the two is reported. `d_rep` means F3 and `d_repne` means F2, and the two are never set together.
- R4: Operand size (66) is handled according to `sse_class`.
  - With `sse_class`=1 and F2 or F3 present, a 66 byte is reported as dropped (`d_opsz_drop`=1, `d_opsz16`=0).
  - With `sse_class`=0, 66 stays in effect next to a repeat prefix, so 66 F3 A5 gives `d_opsz16`=1 and `d_rep`=1.
- R5: A legacy prefix byte that arrives when MAX_LEGACY (default 4) legacy prefixes have already been taken sets `d_err`.
- R6: A legacy prefix after a REX byte sets `d_err` and discards that REX (`d_rex_v`=0, `d_rex`=0). A REX right before the opcode is reported with `d_rex_v`=1 and its low nibble on `d_rex` (W,R,X,B from bit 3 down).
- R7: C4 and C5 end the scan with `d_vex`=1. `d_err` is set as well if REX, 66, F2 or F3 was taken before the escape.
- R8: After the descriptor is registered, `out_valid` and every descriptor field stay constant until `out_ready` is seen, and `in_ready` is low during that time. On acceptance `out_valid` drops, all fields clear to zero, and the next instruction starts from empty prefix state.
- R9: A synchronous active-high `rst` clears the accumulated prefixes, the count and the descriptor. `in_ready` is 1 and `out_valid` is 0 after reset.
- R10: `d_count` gives the number of prefix bytes (legacy and REX) taken before the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| sse_class | input | 1 | Mandatory-prefix opcode class, sampled with the opcode byte |
| in_ready | output | 1 | Block can take a byte |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Downstream accepts descriptor |
| d_lock | output | 1 | Lock prefix present |
| d_rep | output | 1 | F3 is the effective repeat prefix |
| d_repne | output | 1 | F2 is the effective repeat prefix |
| d_seg | output | 3 | Segment override code |
| d_opsz16 | output | 1 | Operand-size override in effect |
| d_opsz_drop | output | 1 | Operand-size prefix ignored |
| d_addr32 | output | 1 | Address-size override present |
| d_rex_v | output | 1 | Valid REX in effect |
| d_rex | output | 4 | REX W,R,X,B bits |
| d_vex | output | 1 | Terminating byte is a VEX escape |
| d_count | output | CNT_W | Prefix bytes taken |
| d_err | output | 1 | Illegal prefix sequence |
| d_opcode | output | 8 | Terminating byte |

## Verification
The embedded assertions check the handshake on every cycle. A held descriptor keeps its opcode and valid flag, and input is refused while it waits. They also check that a legacy byte after REX always raises the error and clears the REX, and that the repeat pair and the operand-size pair are never both set. Order-dependent results can only be shown by the bench's byte sequences. These are last-wins between F2 and F3 or between segment overrides, the mandatory-prefix drop versus the string case, the prefix limit, VEX rejection and the clearing by reset mid-sequence.

// File: rtl/prefix_scan_pkg.sv
package prefix_scan_pkg;

  typedef enum logic [1:0] {
    REP_NONE = 2'd0,
    REP_NE   = 2'd1,
    REP_E    = 2'd2
  } rep_t;

  typedef struct packed {
    logic       legacy;
    logic       rex;
    logic       vex;
    logic       is_lock;
    logic       is_rep;
    logic       is_repne;
    logic       is_seg;
    logic [2:0] seg;
    logic       is_opsz;
    logic       is_addr;
  } cls_t;

  typedef struct packed {
    logic       lock;
    rep_t       rep;
    logic [2:0] seg;
    logic       opsz;
    logic       addr;
    logic       rex_v;
    logic [3:0] rex;
    logic       err;
  } pfx_t;

endpackage

// File: rtl/prefix_classify.sv
module prefix_classify
  import prefix_scan_pkg::*;
(
  input  logic [7:0] byte_i,
  output cls_t       cls_o
);
  always_comb begin
    cls_o = '0;
    unique case (byte_i)
      8'hF0: cls_o.is_lock  = 1'b1;
      8'hF2: cls_o.is_repne = 1'b1;
      8'hF3: cls_o.is_rep   = 1'b1;
      8'h26: begin cls_o.is_seg = 1'b1; cls_o.seg = 3'd1; end
      8'h2E: begin cls_o.is_seg = 1'b1; cls_o.seg = 3'd2; end
      8'h36: begin cls_o.is_seg = 1'b1; cls_o.seg = 3'd3; end
      8'h3E: begin cls_o.is_seg = 1'b1; cls_o.seg = 3'd4; end
      8'h64: begin cls_o.is_seg = 1'b1; cls_o.seg = 3'd5; end
      8'h65: begin cls_o.is_seg = 1'b1; cls_o.seg = 3'd6; end
      8'h66: cls_o.is_opsz  = 1'b1;
      8'h67: cls_o.is_addr  = 1'b1;
      8'hC4, 8'hC5: cls_o.vex = 1'b1;
      default: ;
    endcase
    cls_o.rex    = (byte_i[7:4] == 4'h4);
    cls_o.legacy = cls_o.is_lock | cls_o.is_rep | cls_o.is_repne |
                   cls_o.is_seg  | cls_o.is_opsz | cls_o.is_addr;
  end
endmodule

// File: rtl/prefix_accum.sv
module prefix_accum
  import prefix_scan_pkg::*;
#(
  parameter int MAX_LEGACY = 4,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             clear,
  input  cls_t             cls,
  input  logic [3:0]       rex_bits,
  output pfx_t             st,
  output logic [CNT_W-1:0] total_cnt
);
  localparam int LCNT_W = $clog2(MAX_LEGACY + 1) + 1;
  localparam logic [LCNT_W-1:0] LIMIT = LCNT_W'(MAX_LEGACY);
  localparam logic [CNT_W-1:0]  CMAX  = {CNT_W{1'b1}};

  logic [LCNT_W-1:0] leg_cnt;
  pfx_t              nxt;

  always_comb begin
    nxt = st;
    if (cls.legacy) begin
      if (leg_cnt >= LIMIT) nxt.err = 1'b1;
      if (st.rex_v) begin
        nxt.err   = 1'b1;
        nxt.rex_v = 1'b0;
        nxt.rex   = 4'h0;
      end
    end
    if (cls.is_lock)  nxt.lock = 1'b1;
    if (cls.is_rep)   nxt.rep  = REP_E;
    if (cls.is_repne) nxt.rep  = REP_NE;
    if (cls.is_seg)   nxt.seg  = cls.seg;
    if (cls.is_opsz)  nxt.opsz = 1'b1;
    if (cls.is_addr)  nxt.addr = 1'b1;
    if (cls.rex) begin
      nxt.rex_v = 1'b1;
      nxt.rex   = rex_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st        <= '0;
      leg_cnt   <= '0;
      total_cnt <= '0;
    end else if (take) begin
      st <= nxt;
      if (cls.legacy && leg_cnt != {LCNT_W{1'b1}}) leg_cnt <= leg_cnt + 1'b1;
      if (total_cnt != CMAX) total_cnt <= total_cnt + 1'b1;
    end
  end

  // R6: legacy byte after REX must flag and drop the REX
  a_r6_rex_dropped: assert property (@(posedge clk) disable iff (rst)
    (take && !clear && cls.legacy && st.rex_v) |=> (st.err && !st.rex_v));
endmodule

// File: rtl/prefix_desc_reg.sv
module prefix_desc_reg
  import prefix_scan_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             accept,
  input  pfx_t             pfx_in,
  input  logic             sse_in,
  input  logic             vex_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [7:0]       op_in,
  output logic             valid,
  output logic             lock,
  output logic             rep,
  output logic             repne,
  output logic [2:0]       seg,
  output logic             opsz16,
  output logic             opsz_drop,
  output logic             addr32,
  output logic             rex_v,
  output logic [3:0]       rex,
  output logic             vex,
  output logic [CNT_W-1:0] cnt,
  output logic             err,
  output logic [7:0]       opcode
);
  logic any_rep, drop, vex_bad;
  assign any_rep = (pfx_in.rep != REP_NONE);
  assign drop    = pfx_in.opsz && sse_in && any_rep;
  assign vex_bad = vex_in && (pfx_in.rex_v || pfx_in.opsz || any_rep);

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      valid <= 1'b0; lock <= 1'b0; rep <= 1'b0; repne <= 1'b0;
      seg <= '0; opsz16 <= 1'b0; opsz_drop <= 1'b0; addr32 <= 1'b0;
      rex_v <= 1'b0; rex <= '0; vex <= 1'b0; cnt <= '0; err <= 1'b0;
      opcode <= '0;
    end else if (load) begin
      valid     <= 1'b1;
      lock      <= pfx_in.lock;
      rep       <= (pfx_in.rep == REP_E);
      repne     <= (pfx_in.rep == REP_NE);
      seg       <= pfx_in.seg;
      opsz16    <= pfx_in.opsz && !drop;
      opsz_drop <= drop;
      addr32    <= pfx_in.addr;
      rex_v     <= pfx_in.rex_v;
      rex       <= pfx_in.rex;
      vex       <= vex_in;
      cnt       <= cnt_in;
      err       <= pfx_in.err || vex_bad;
      opcode    <= op_in;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !accept) |=> (valid && $stable(opcode) && $stable(err)));
  a_r3_rep_excl: assert property (@(posedge clk) disable iff (rst)
    !(rep && repne));
  a_r4_opsz_excl: assert property (@(posedge clk) disable iff (rst)
    !(opsz16 && opsz_drop));
endmodule

// File: rtl/prefix_scan.sv
module prefix_scan
  import prefix_scan_pkg::*;
#(
  parameter int MAX_LEGACY = 4,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             sse_class,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             d_lock,
  output logic             d_rep,
  output logic             d_repne,
  output logic [2:0]       d_seg,
  output logic             d_opsz16,
  output logic             d_opsz_drop,
  output logic             d_addr32,
  output logic             d_rex_v,
  output logic [3:0]       d_rex,
  output logic             d_vex,
  output logic [CNT_W-1:0] d_count,
  output logic             d_err,
  output logic [7:0]       d_opcode
);
  cls_t             cls;
  pfx_t             st;
  logic [CNT_W-1:0] cnt;
  logic             fire, take_pfx, capture, accept;

  assign in_ready = !out_valid;
  assign fire     = in_valid && in_ready;
  assign take_pfx = fire && (cls.legacy || cls.rex);
  assign capture  = fire && !(cls.legacy || cls.rex);
  assign accept   = out_valid && out_ready;

  prefix_classify u_cls (.byte_i(in_byte), .cls_o(cls));

  prefix_accum #(.MAX_LEGACY(MAX_LEGACY), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .take(take_pfx), .clear(capture),
    .cls(cls), .rex_bits(in_byte[3:0]), .st(st), .total_cnt(cnt));

  prefix_desc_reg #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .load(capture), .accept(accept),
    .pfx_in(st), .sse_in(sse_class), .vex_in(cls.vex), .cnt_in(cnt),
    .op_in(in_byte), .valid(out_valid), .lock(d_lock), .rep(d_rep),
    .repne(d_repne), .seg(d_seg), .opsz16(d_opsz16),
    .opsz_drop(d_opsz_drop), .addr32(d_addr32), .rex_v(d_rex_v),
    .rex(d_rex), .vex(d_vex), .cnt(d_count), .err(d_err),
    .opcode(d_opcode));

  a_r8_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
endmodule

// File: tb/prefix_scan_test.sv
module prefix_scan_test;
  localparam int CNT_W = 4;
  localparam int NV    = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, sse_class = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, d_lock, d_rep, d_repne, d_opsz16, d_opsz_drop;
  logic d_addr32, d_rex_v, d_vex, d_err;
  logic [2:0] d_seg;
  logic [3:0] d_rex;
  logic [CNT_W-1:0] d_count;
  logic [7:0] d_opcode;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  prefix_scan #(.MAX_LEGACY(4), .CNT_W(CNT_W)) uut (.*);

  // {lock,rep,repne,seg3,opsz16,drop,addr,rexv,rex4,vex,cnt4,err,op8}
  localparam logic [47:0] VB [NV] = '{
    48'h000000A5F366, 48'h0000000FF366, 48'h00000090F2F3, 48'h00000090F3F2,
    48'h0000008B642E, 48'h0000000148F0, 48'h000000016648, 48'h00000000C566,
    48'h00000000C426, 48'h0090F0366567, 48'h90F0F0F0F0F0, 48'h000000009041,
    48'h000000000090, 48'h00000000C44C};
  localparam int VL [NV] = '{3, 3, 3, 3, 3, 3, 3, 2, 2, 5, 6, 2, 1, 2};
  localparam logic VS [NV] = '{0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam string VR [NV] = '{"R4", "R4", "R3", "R3", "R2", "R6", "R6",
    "R7", "R7", "R2", "R5", "R10", "R1", "R7"};
  localparam logic [27:0] VE [NV] = '{
    {1'b0,1'b1,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,4'd2,1'b0,8'hA5},
    {1'b0,1'b1,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,4'd2,1'b0,8'h0F},
    {1'b0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'd2,1'b0,8'h90},
    {1'b0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'd2,1'b0,8'h90},
    {1'b0,1'b0,1'b0,3'd5,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'd2,1'b0,8'h8B},
    {1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,4'h8,1'b0,4'd2,1'b0,8'h01},
    {1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,4'd2,1'b1,8'h01},
    {1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,4'h0,1'b1,4'd1,1'b1,8'hC5},
    {1'b0,1'b0,1'b0,3'd1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,4'd1,1'b0,8'hC4},
    {1'b1,1'b0,1'b0,3'd3,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,4'd4,1'b0,8'h90},
    {1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'd5,1'b1,8'h90},
    {1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,4'h1,1'b0,4'd1,1'b0,8'h90},
    {1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'd0,1'b0,8'h90},
    {1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,4'hC,1'b1,4'd1,1'b1,8'hC4}};

  function automatic logic [27:0] got();
    return {d_lock, d_rep, d_repne, d_seg, d_opsz16, d_opsz_drop, d_addr32,
            d_rex_v, d_rex, d_vex, d_count, d_err, d_opcode};
  endfunction

  task automatic check(input string req, input logic [27:0] act,
                       input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] bytes, input int len, input logic sse);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_byte = bytes[i*8 +: 8]; in_valid = 1'b1; sse_class = sse;
    end
    @(negedge clk);
    in_valid = 1'b0; sse_class = 1'b0;
  endtask

  task automatic release_desc();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9", {26'd0, in_ready, out_valid}, {26'd0, 2'b10});
    check("R9", got(), 28'd0);

    for (int v = 0; v < NV; v++) begin
      send(VB[v], VL[v], VS[v]);
      check(VR[v], {27'd0, out_valid}, 28'd1);
      check(VR[v], got(), VE[v]);
      release_desc();
    end

    // R8: hold while out_ready low, input refused, then clear
    send(48'h90, 1, 1'b0);
    @(negedge clk); in_byte = 8'h66; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", {26'd0, out_valid, in_ready}, {26'd0, 2'b10});
    check("R8", got(), {20'd0, 8'h90});
    in_valid = 1'b0;
    release_desc();
    check("R8", {27'd0, out_valid}, 28'd0);
    check("R8", got(), 28'd0);
    send(48'h90, 1, 1'b0);
    check("R8", got(), {20'd0, 8'h90});
    release_desc();

    // R9: reset in the middle of a prefix run clears the partial state
    send(48'hF066, 2, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(48'h90, 1, 1'b0);
    check("R9", got(), {20'd0, 8'h90});
    release_desc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule